// File: doc/BRIEF.md
# DDR2 Command Decoder and Power-State Tracker

This block watches the control pins of a DDR2 memory device and names the command carried on each rising clock edge. It looks at the clock-enable level of the current cycle and, through a register of its own, of the cycle before. With chip select, the three strobes, the bank bits and the address bus, it produces a command code, the bank and address that command uses, and a flag for the auto-precharge variants of reads and writes. All of these appear one cycle after the sampling edge.

Alongside the decoder, the block follows the device's power state: active, power-down or self-refresh. It moves between these states on edges of clock-enable. It raises an illegal flag for sequences the device forbids. These are a read or write that cuts into a short burst, a command on a clock-enable edge that only allows an idle encoding, and the reserved strobe pattern. Since a powered-down device does not refresh itself, the block counts the cycles spent in power-down and raises a warning once a configurable limit is passed. A monitor or a controller self-check would place it on the command bus.

Top module: `ddr2_cmd_monitor`

## Requirements
- R1: While reset is held, the outputs are: command code 0 (none), power state 0 (active), illegal 0, warning 0, bank 0, address 0 and auto-precharge 0. The stored previous clock-enable is high and the burst counter is cleared.
- R2: With clock-enable high in both cycles, the decode follows the active-low pins (cs_n, ras_n, cas_n, we_n). Chip select high gives code 1 (deselect). The strobe patterns ras/cas/we give: 111 → 2 (no-op), 000 → 3 (mode set), 001 → 4 (refresh), 010 → 9/10 (precharge), 011 → 11 (activate), 100 → 12/13 (write), 101 → 14/15 (read). Pattern 110 gives code 0 with illegal set. The result is registered and visible one cycle after the sampling edge.
- R3: When clock-enable falls from high to low, the refresh pattern gives code 5 (self-refresh entry) and state 2 (self-refresh). A deselect or no-op gives code 7 (power-down entry) and state 1 (power-down). Any other pattern gives code 0, sets illegal, and enters state 1.
- R4: With clock-enable low in both cycles, the code is 0 and the power state does not change, whatever the other pins carry.
- R5: When clock-enable rises from low to high, the code is 6 (self-refresh exit) if the state was self-refresh, or 8 (power-down exit) otherwise, and the state returns to active. The other pins do not affect the code. If chip select is low with a strobe pattern other than 111, illegal is also set.
- R6: For precharge, address bit 10 low gives code 9 with the bank output set to the bank input. Address bit 10 high gives code 10 with the bank output 0, whatever the bank input.
- R7: For reads and writes, address bit 10 high selects the auto-precharge code (13 write, 15 read) and sets the auto-precharge output. Bit 10 low selects the plain code (12, 14). The address output is the low COL_W address bits, zero-extended, and the bank output is the bank input.
- R8: For a mode set, the bank output carries the bank input, which selects the mode register, and the address output carries the full address bus as the op-code.
- R9: A read or write accepted while no burst is running starts a burst of BURST_LEN/2 cycles. A read or write that arrives before that many cycles have passed sets illegal and does not restart the burst.
- R10: A counter runs for each cycle the state is power-down and clears outside it. The warning is high while the state is power-down and the count exceeds PD_LIMIT. It stays low in self-refresh.
- R11: For commands that carry no bank or address (deselect, no-op, refresh, precharge-all, entries, exits, none), the bank and address outputs are 0. The auto-precharge output is 0 for every code except 13 and 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock, rising edge samples pins |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock-enable pin, current cycle |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank address pins |
| addr | input | ADDR_W | Address pins |
| cmd_code | output | 4 | Registered command code |
| cmd_bank | output | BA_W | Registered bank of the command |
| cmd_addr | output | ADDR_W | Registered row, column or op-code |
| cmd_ap | output | 1 | Registered auto-precharge flag |
| pwr_state | output | 2 | Power state: 0 active, 1 power-down, 2 self-refresh |
| illegal | output | 1 | Registered illegal-sequence flag |
| refresh_warn | output | 1 | Power-down duration exceeded limit |

## Verification
A wrong stored clock-enable or power state shows at the next edge of clock-enable. The exit code comes out as the wrong type of exit, or an entry or exit appears where none belongs, one cycle after that edge. A burst counter that is off by one flags a legal read two cycles after another, or misses the back-to-back clash, on the cycle after the second command. A power-down counter error moves the warning's first cycle by one or more cycles away from PD_LIMIT+1 cycles after entry, which a held power-down followed cycle by cycle exposes.

// File: rtl/ddr2_mon_pkg.sv
// Shared types for the DDR2 command monitor.
// Assumes: code values are visible at the top ports and are fixed.
package ddr2_mon_pkg;

    typedef enum logic [3:0] {
        C_NONE      = 4'd0,
        C_DESEL     = 4'd1,
        C_NOP       = 4'd2,
        C_MRS       = 4'd3,
        C_REF       = 4'd4,
        C_SREF_IN   = 4'd5,
        C_SREF_OUT  = 4'd6,
        C_PD_IN     = 4'd7,
        C_PD_OUT    = 4'd8,
        C_PRE_ONE   = 4'd9,
        C_PRE_ALL   = 4'd10,
        C_ACT       = 4'd11,
        C_WR        = 4'd12,
        C_WR_AP     = 4'd13,
        C_RD        = 4'd14,
        C_RD_AP     = 4'd15
    } cmd_e;

    typedef enum logic [1:0] {
        PS_ACTIVE = 2'd0,
        PS_PDOWN  = 2'd1,
        PS_SREF   = 2'd2
    } pstate_e;

endpackage

// File: rtl/ddr2_pin_decode.sv
// Combinational classifier for one sampled cycle of DDR2 control pins.
// Assumes: cke_prev is the clock-enable sampled on the previous edge and
// in_sref tells whether the tracked power state is self-refresh.
module ddr2_pin_decode
    import ddr2_mon_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int BA_W   = 3,
    parameter int COL_W  = 10,
    parameter int AP_BIT = 10
) (
    input  logic              cke_prev,
    input  logic              cke,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [BA_W-1:0]   ba,
    input  logic [ADDR_W-1:0] addr,
    input  logic              in_sref,
    output cmd_e              cmd,
    output logic [BA_W-1:0]   bank_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              ap,
    output logic              rdwr,
    output logic              bad_cmd
);

    localparam int PAD_W = ADDR_W - COL_W;

    logic [2:0]        strobes;
    logic [ADDR_W-1:0] col_ext;

    assign strobes = {ras_n, cas_n, we_n};
    assign col_ext = {{PAD_W{1'b0}}, addr[COL_W-1:0]};

    // Classify the cycle from the clock-enable history and the strobes.
    always_comb begin
        cmd     = C_NONE;
        bank_o  = '0;
        addr_o  = '0;
        ap      = 1'b0;
        rdwr    = 1'b0;
        bad_cmd = 1'b0;
        unique case ({cke_prev, cke})
            2'b11: begin
                if (cs_n) begin
                    cmd = C_DESEL;
                end else begin
                    unique case (strobes)
                        3'b111: cmd = C_NOP;
                        3'b000: begin
                            cmd    = C_MRS;
                            bank_o = ba;
                            addr_o = addr;
                        end
                        3'b001: cmd = C_REF;
                        3'b010: begin
                            if (addr[AP_BIT]) begin
                                cmd = C_PRE_ALL;
                            end else begin
                                cmd    = C_PRE_ONE;
                                bank_o = ba;
                            end
                        end
                        3'b011: begin
                            cmd    = C_ACT;
                            bank_o = ba;
                            addr_o = addr;
                        end
                        3'b100: begin
                            cmd    = addr[AP_BIT] ? C_WR_AP : C_WR;
                            bank_o = ba;
                            addr_o = col_ext;
                            ap     = addr[AP_BIT];
                            rdwr   = 1'b1;
                        end
                        3'b101: begin
                            cmd    = addr[AP_BIT] ? C_RD_AP : C_RD;
                            bank_o = ba;
                            addr_o = col_ext;
                            ap     = addr[AP_BIT];
                            rdwr   = 1'b1;
                        end
                        default: bad_cmd = 1'b1;
                    endcase
                end
            end
            2'b10: begin
                if (cs_n || strobes == 3'b111) begin
                    cmd = C_PD_IN;
                end else if (strobes == 3'b001) begin
                    cmd = C_SREF_IN;
                end else begin
                    bad_cmd = 1'b1;
                end
            end
            2'b01: begin
                cmd     = in_sref ? C_SREF_OUT : C_PD_OUT;
                bad_cmd = !cs_n && (strobes != 3'b111);
            end
            default: cmd = C_NONE;
        endcase
    end

endmodule

// File: rtl/ddr2_burst_guard.sv
// Tracks the remaining cycles of a fixed-length burst and flags overlap.
// Assumes: is_rdwr is high only for a decoded read or write; a clashing
// command does not restart the burst.
module ddr2_burst_guard #(
    parameter int BURST_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic is_rdwr,
    output logic clash
);

    localparam int BURST_CYC = BURST_LEN / 2;
    localparam int CNT_W     = $clog2(BURST_CYC + 1);

    logic [CNT_W-1:0] cnt_q;

    assign clash = is_rdwr && (cnt_q != '0);

    // Load on an accepted burst, otherwise count down to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (is_rdwr && cnt_q == '0) begin
            cnt_q <= CNT_W'(BURST_CYC - 1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    a_r9_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rdwr && cnt_q == '0) |=> (cnt_q == CNT_W'(BURST_CYC - 1)));

    a_r9_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

endmodule

// File: rtl/ddr2_power_track.sv
// Power-state machine driven by clock-enable edges, with a power-down
// duration counter and warning.
// Assumes: sref_entry is the decoder's self-refresh entry indication.
module ddr2_power_track
    import ddr2_mon_pkg::*;
#(
    parameter int PD_LIMIT = 8
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    cke_prev,
    input  logic    cke,
    input  logic    sref_entry,
    output pstate_e state,
    output logic    warn
);

    localparam int CNT_W = $clog2(PD_LIMIT + 2);
    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(PD_LIMIT + 1);

    pstate_e          state_q;
    logic [CNT_W-1:0] cnt_q;

    assign state = state_q;
    assign warn  = (state_q == PS_PDOWN) && (cnt_q > CNT_W'(PD_LIMIT));

    // Move between states on clock-enable edges only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_ACTIVE;
        end else if (cke_prev && !cke) begin
            state_q <= sref_entry ? PS_SREF : PS_PDOWN;
        end else if (!cke_prev && cke) begin
            state_q <= PS_ACTIVE;
        end
    end

    // Count power-down cycles, saturating just past the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (state_q != PS_PDOWN) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_SAT) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    a_r4_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_prev && !cke) |=> $stable(state_q));

    a_r5_rise_active: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_prev && cke) |=> (state_q == PS_ACTIVE));

    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != PS_PDOWN) |=> (cnt_q == '0));

    a_r3_known_state: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_ACTIVE || state_q == PS_PDOWN || state_q == PS_SREF));

endmodule

// File: rtl/ddr2_cmd_monitor.sv
// Top of the DDR2 command monitor: keeps the previous clock-enable,
// decodes each cycle, registers the result and tracks power and bursts.
// Assumes: pins are synchronous to clk; outputs lag the sampling edge by
// one cycle.
module ddr2_cmd_monitor
    import ddr2_mon_pkg::*;
#(
    parameter int ADDR_W    = 14,
    parameter int BA_W      = 3,
    parameter int COL_W     = 10,
    parameter int BURST_LEN = 4,
    parameter int PD_LIMIT  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [BA_W-1:0]   ba,
    input  logic [ADDR_W-1:0] addr,
    output logic [3:0]        cmd_code,
    output logic [BA_W-1:0]   cmd_bank,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              cmd_ap,
    output logic [1:0]        pwr_state,
    output logic              illegal,
    output logic              refresh_warn
);

    localparam int AP_BIT = 10;

    logic              cke_prev;
    cmd_e              dec_cmd;
    logic [BA_W-1:0]   dec_bank;
    logic [ADDR_W-1:0] dec_addr;
    logic              dec_ap;
    logic              dec_rdwr;
    logic              dec_bad;
    logic              burst_clash;
    pstate_e           state;

    cmd_e              cmd_q;
    logic [BA_W-1:0]   bank_q;
    logic [ADDR_W-1:0] addr_q;
    logic              ap_q;
    logic              ill_q;

    // Remember clock-enable from the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) cke_prev <= 1'b1;
        else        cke_prev <= cke;
    end

    ddr2_pin_decode #(
        .ADDR_W (ADDR_W),
        .BA_W   (BA_W),
        .COL_W  (COL_W),
        .AP_BIT (AP_BIT)
    ) u_decode (
        .cke_prev (cke_prev),
        .cke      (cke),
        .cs_n     (cs_n),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .ba       (ba),
        .addr     (addr),
        .in_sref  (state == PS_SREF),
        .cmd      (dec_cmd),
        .bank_o   (dec_bank),
        .addr_o   (dec_addr),
        .ap       (dec_ap),
        .rdwr     (dec_rdwr),
        .bad_cmd  (dec_bad)
    );

    ddr2_burst_guard #(
        .BURST_LEN (BURST_LEN)
    ) u_burst (
        .clk     (clk),
        .rst_n   (rst_n),
        .is_rdwr (dec_rdwr),
        .clash   (burst_clash)
    );

    ddr2_power_track #(
        .PD_LIMIT (PD_LIMIT)
    ) u_power (
        .clk        (clk),
        .rst_n      (rst_n),
        .cke_prev   (cke_prev),
        .cke        (cke),
        .sref_entry (dec_cmd == C_SREF_IN),
        .state      (state),
        .warn       (refresh_warn)
    );

    // Register the decoded command and its fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= C_NONE;
            bank_q <= '0;
            addr_q <= '0;
            ap_q   <= 1'b0;
            ill_q  <= 1'b0;
        end else begin
            cmd_q  <= dec_cmd;
            bank_q <= dec_bank;
            addr_q <= dec_addr;
            ap_q   <= dec_ap;
            ill_q  <= dec_bad || burst_clash;
        end
    end

    assign cmd_code  = cmd_q;
    assign cmd_bank  = bank_q;
    assign cmd_addr  = addr_q;
    assign cmd_ap    = ap_q;
    assign illegal   = ill_q;
    assign pwr_state = state;

    a_r7_ap_only_rdwr: assert property (@(posedge clk) disable iff (!rst_n)
        ap_q |-> (cmd_q == C_RD_AP || cmd_q == C_WR_AP));

    a_r2_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        (cke_prev && cke && cs_n) |=> (cmd_q == C_DESEL && bank_q == '0));

    a_r5_exit_code: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_prev && cke) |=> (cmd_q == C_PD_OUT || cmd_q == C_SREF_OUT));

endmodule

// File: tb/tb_ddr2_cmd_monitor.sv
`timescale 1ns/1ps
module tb_ddr2_cmd_monitor;

    localparam int ADDR_W    = 14;
    localparam int BA_W      = 3;
    localparam int COL_W     = 10;
    localparam int BURST_LEN = 4;
    localparam int PD_LIMIT  = 8;
    localparam int BC        = BURST_LEN / 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cke = 1'b1;
    logic              cs_n = 1'b1;
    logic              ras_n = 1'b1;
    logic              cas_n = 1'b1;
    logic              we_n = 1'b1;
    logic [BA_W-1:0]   ba = '0;
    logic [ADDR_W-1:0] addr = '0;
    logic [3:0]        cmd_code;
    logic [BA_W-1:0]   cmd_bank;
    logic [ADDR_W-1:0] cmd_addr;
    logic              cmd_ap;
    logic [1:0]        pwr_state;
    logic              illegal;
    logic              refresh_warn;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // Model state from the requirements.
    int m_prev, m_state, m_burst, m_pd;
    int e_cmd, e_bank, e_addr, e_ap, e_ill, e_state, e_warn;
    string e_tag, e_ill_tag;

    always #10 clk = ~clk;

    ddr2_cmd_monitor #(
        .ADDR_W (ADDR_W), .BA_W (BA_W), .COL_W (COL_W),
        .BURST_LEN (BURST_LEN), .PD_LIMIT (PD_LIMIT)
    ) dut (
        .clk (clk), .rst_n (rst_n), .cke (cke), .cs_n (cs_n),
        .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n), .ba (ba),
        .addr (addr), .cmd_code (cmd_code), .cmd_bank (cmd_bank),
        .cmd_addr (cmd_addr), .cmd_ap (cmd_ap), .pwr_state (pwr_state),
        .illegal (illegal), .refresh_warn (refresh_warn)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic string tag_of(input int c);
        case (c)
            0: return "R4";
            1, 2, 4, 11: return "R2";
            3: return "R8";
            5, 7: return "R3";
            6, 8: return "R5";
            9, 10: return "R6";
            default: return "R7";
        endcase
    endfunction

    // Expected outputs for the pins presented now, and model update.
    task automatic model_step();
        int st;
        bit rdwr;
        bit fall;
        bit rise;
        st = {ras_n, cas_n, we_n};
        e_cmd = 0; e_bank = 0; e_addr = 0; e_ap = 0; e_ill = 0;
        e_ill_tag = "R2";
        rdwr = 0;
        fall = (m_prev == 1) && !cke;
        rise = (m_prev == 0) && cke;
        if (m_prev == 1 && cke) begin
            if (cs_n) e_cmd = 1;
            else case (st)
                7: e_cmd = 2;
                0: begin e_cmd = 3; e_bank = ba; e_addr = addr; end
                1: e_cmd = 4;
                2: if (addr[10]) e_cmd = 10; else begin e_cmd = 9; e_bank = ba; end
                3: begin e_cmd = 11; e_bank = ba; e_addr = addr; end
                4, 5: begin
                    e_cmd = (st == 4 ? 12 : 14) + (addr[10] ? 1 : 0);
                    e_bank = ba; e_addr = addr & ((1 << COL_W) - 1);
                    e_ap = addr[10]; rdwr = 1;
                end
                default: e_ill = 1;
            endcase
        end else if (fall) begin
            e_ill_tag = "R3";
            if (cs_n || st == 7) e_cmd = 7;
            else if (st == 1) e_cmd = 5;
            else e_ill = 1;
        end else if (rise) begin
            e_ill_tag = "R5";
            e_cmd = (m_state == 2) ? 6 : 8;
            if (!cs_n && st != 7) e_ill = 1;
        end
        if (rdwr) begin
            if (m_burst != 0) begin e_ill = 1; e_ill_tag = "R9"; m_burst--; end
            else m_burst = BC - 1;
        end else if (m_burst != 0) m_burst--;
        if (m_state == 1) begin if (m_pd <= PD_LIMIT) m_pd++; end
        else m_pd = 0;
        if (fall) m_state = (e_cmd == 5) ? 2 : 1;
        else if (rise) m_state = 0;
        m_prev = cke;
        e_state = m_state;
        e_warn = (m_state == 1 && m_pd > PD_LIMIT) ? 1 : 0;
        e_tag = tag_of(e_cmd);
    endtask

    // One cycle: drive at negedge, let the edge sample, compare after it.
    task automatic cyc(input bit k, input bit cs, input bit r, input bit c,
                       input bit w, input int b, input int a);
        cke = k; cs_n = cs; ras_n = r; cas_n = c; we_n = w;
        ba = BA_W'(b); addr = ADDR_W'(a);
        model_step();
        @(posedge clk);
        @(negedge clk);
        chk(e_tag, "cmd_code", cmd_code, e_cmd);
        chk(e_tag, "cmd_bank R11", cmd_bank, e_bank);
        chk(e_tag, "cmd_addr R11", cmd_addr, e_addr);
        chk(e_tag, "cmd_ap R11", cmd_ap, e_ap);
        chk(e_ill_tag, "illegal", illegal, e_ill);
        chk(e_tag, "pwr_state", pwr_state, e_state);
        chk("R10", "refresh_warn", refresh_warn, e_warn);
    endtask

    initial begin
        int k;
        void'($urandom(32'd20240611));
        m_prev = 1; m_state = 0; m_burst = 0; m_pd = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset values
        chk("R1", "cmd_code", cmd_code, 0);
        chk("R1", "pwr_state", pwr_state, 0);
        chk("R1", "illegal", illegal, 0);
        chk("R1", "refresh_warn", refresh_warn, 0);
        chk("R1", "cmd_bank", cmd_bank, 0);
        chk("R1", "cmd_addr", cmd_addr, 0);
        rst_n = 1'b1;

        // R2 / R11: basic decode
        cyc(1, 1, 0, 0, 0, 5, 14'h1fff);       // deselect, fields zero
        cyc(1, 0, 1, 1, 1, 4, 14'h0123);       // no-op
        cyc(1, 0, 0, 1, 1, 5, 14'h1abc);       // activate
        cyc(1, 0, 0, 0, 1, 7, 14'h3fff);       // refresh
        cyc(1, 0, 1, 1, 0, 2, 14'h0055);       // reserved -> illegal
        // R8: mode set
        cyc(1, 0, 0, 0, 0, 1, 14'h0442);
        // R6: precharge one / all
        cyc(1, 0, 0, 1, 0, 3, 14'h0000);
        cyc(1, 0, 0, 1, 0, 6, 14'h0400);
        // R7: write with auto-precharge, plain read
        cyc(1, 0, 1, 0, 0, 2, 14'h0555);
        cyc(1, 0, 1, 1, 1, 0, 0);
        cyc(1, 0, 1, 1, 1, 0, 0);
        cyc(1, 0, 1, 0, 1, 6, 14'h2123);
        cyc(1, 0, 1, 1, 1, 0, 0);
        cyc(1, 0, 1, 1, 1, 0, 0);
        // R9: back-to-back clash, then spaced legal
        cyc(1, 0, 1, 0, 1, 1, 14'h0010);
        cyc(1, 0, 1, 0, 1, 1, 14'h0020);
        cyc(1, 0, 1, 0, 0, 1, 14'h0030);
        cyc(1, 0, 1, 1, 1, 0, 0);
        cyc(1, 0, 1, 0, 0, 1, 14'h0430);
        cyc(1, 1, 1, 1, 1, 0, 0);
        // R3 / R4 / R10: power-down held past the limit, clean exit R5
        cyc(0, 0, 1, 1, 1, 0, 0);
        for (int i = 0; i < PD_LIMIT + 4; i++) cyc(0, 0, 0, 0, 0, 7, 14'h3fff);
        cyc(1, 0, 1, 1, 1, 0, 0);
        cyc(1, 1, 1, 1, 1, 0, 0);
        // R3 / R10: self-refresh held, no warning; R5 exit with command
        cyc(0, 0, 0, 0, 1, 0, 0);
        for (int i = 0; i < PD_LIMIT + 4; i++) cyc(0, 1, 1, 1, 1, 0, 0);
        cyc(1, 0, 0, 1, 1, 2, 14'h0100);
        cyc(1, 1, 1, 1, 1, 0, 0);
        // R3: fall while a read is presented
        cyc(0, 0, 1, 0, 1, 0, 0);
        cyc(0, 1, 1, 1, 1, 0, 0);
        cyc(1, 1, 1, 1, 1, 0, 0);

        // Constrained random traffic
        k = 1;
        for (int i = 0; i < 3000; i++) begin
            int pins;
            if (k == 1 && ($urandom % 20) == 0) k = 0;
            else if (k == 0 && ($urandom % 12) == 0) k = 1;
            pins = $urandom % 16;
            if (pins >= 8) pins = 5 - (pins % 2);   // favour reads/writes
            cyc(k[0], ($urandom % 8) == 0, pins[2], pins[1], pins[0],
                $urandom % 8, $urandom % 16384);
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule